// File: doc/BRIEF.md
# Multi-Word Multiply-Accumulate Unit

This unit does the inner step of big-number multiplication. It holds a multiplier of up to three 64-bit limbs and a running carry of three 64-bit limbs. Each operation takes two 64-bit operands, `a` and `b`. It multiplies the stored multiplier by `a`, then adds `b` and the stored carry words. The lowest 64-bit limb of the sum is returned. The upper limbs go back into the carry store for the next call. Software loads the multiplier once and issues one operation per limb of the other factor, so a long product is built up one limb at a time.

Two operation kinds exist. The one-limb kind uses only the lowest multiplier word and the lowest carry word, and gives a 128-bit sum. The full kind uses the whole 192-bit multiplier and all three carry words, and gives a 256-bit sum. One 64x64 partial product is formed per cycle, and one extra cycle then folds in the addends.

Requests use a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The result is offered with `res_valid` and stays stable until the consumer raises `res_ready`. No new request is taken before the pending result has been accepted. The multiplier and carry words each have a plain load port, and the carry words are also visible on a flat output.

Top module: `mwmac_unit`

## Requirements
- R1: A synchronous active-high `rst` clears all multiplier and carry words to zero. After reset, `req_ready` is 1 and `res_valid` is 0.
- R2: A pulse on `mpl_wr_en` or `p_wr_en` with an index from 0 to 2 loads that 64-bit word. Index 3 is ignored. Carry word i appears at `p_q[64*i+63:64*i]`.
- R3: An operation with `req_op`=0 returns the low 64 bits of MPL0*a + b + P0, with unsigned 128-bit arithmetic. P0 becomes bits 127:64 of that sum. P1 and P2 keep their values.
- R4: An operation with `req_op`=1 forms the 256-bit sum {MPL2,MPL1,MPL0}*a + b + {P2,P1,P0}. It returns bits 63:0. Bits 127:64, 191:128 and 255:192 go to P0, P1 and P2.
- R5: Carries ripple across every limb. With all-ones operands and state the sum fits exactly and no carry is lost: the full kind gives all-ones result and carry words, and the one-limb kind gives an all-ones result and P0.
- R6: `res_valid` rises on the 2nd clock edge after acceptance for `req_op`=0, and on the 4th edge for `req_op`=1.
- R7: `req_ready` is high only while no operation or result is outstanding. While `res_valid` is high and `res_ready` is low, `res_data` and `res_valid` hold. The result is consumed on an edge where `res_valid` and `res_ready` are both high.
- R8: A carry-word load in the same cycle as an operation's write-back is dropped for the words that operation writes. Loads to other words still take effect.
- R9: Multiplier loads are ignored while `req_ready` is low.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Operation request valid |
| req_ready | output | 1 | Unit can take a request |
| req_op | input | 1 | 0 = one-limb, 1 = full three-limb |
| req_a | input | 64 | Multiplicand operand |
| req_b | input | 64 | Addend operand |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes result |
| res_data | output | 64 | Low limb of the sum |
| mpl_wr_en | input | 1 | Multiplier word load strobe |
| mpl_wr_idx | input | 2 | Multiplier word index |
| mpl_wr_data | input | 64 | Multiplier word value |
| p_wr_en | input | 1 | Carry word load strobe |
| p_wr_idx | input | 2 | Carry word index |
| p_wr_data | input | 64 | Carry word value |
| p_q | output | 192 | Carry words, P0 in the low bits |

## Verification
The checks assume the sum of the product and the addends never needs a bit above the top limb. That holds for any unsigned operand values, and the all-ones stimulus tests exactly that edge. They also assume that carry words read by a running operation are not reloaded during its multiply cycles. The stimulus only loads carry words between operations, except in the write-back collision scenario, where the load lands in the write-back cycle itself. Multiplier loads during a busy period are sent on purpose, and the expected results assume those loads are dropped.

// File: rtl/mwmac_pkg.sv
package mwmac_pkg;
  typedef enum logic {OP_ONE = 1'b0, OP_ALL = 1'b1} op_e;
  typedef enum logic [1:0] {S_IDLE, S_MUL, S_FIN, S_RESP} state_e;
endpackage

// File: rtl/mwmac_limb_mul.sv
module mwmac_limb_mul #(
  parameter int LIMB_W = 64
) (
  input  logic [LIMB_W-1:0]   x,
  input  logic [LIMB_W-1:0]   y,
  output logic [2*LIMB_W-1:0] prod
);
  assign prod = (2*LIMB_W)'(x) * (2*LIMB_W)'(y);
endmodule

// File: rtl/mwmac_accum.sv
module mwmac_accum #(
  parameter int LIMB_W  = 64,
  parameter int N_LIMBS = 3,
  parameter int IDX_W   = 2,
  localparam int ACC_W  = LIMB_W * (N_LIMBS + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 mul_en,
  input  logic [IDX_W-1:0]     mul_idx,
  input  logic [2*LIMB_W-1:0]  prod,
  input  logic                 fin_en,
  input  logic [ACC_W-1:0]     addend,
  output logic [ACC_W-1:0]     fin_sum
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] prod_sh;
  logic [ACC_W-1:0] mul_sum;
  logic             fin_carry;

  // place the partial product at its limb position
  assign prod_sh = ACC_W'(prod) << (int'(mul_idx) * LIMB_W);
  assign mul_sum = acc_q + prod_sh;
  assign {fin_carry, fin_sum} = {1'b0, acc_q} + {1'b0, addend};

  always_ff @(posedge clk) begin
    if (rst || clr) acc_q <= '0;
    else if (mul_en) acc_q <= mul_sum;
  end

  // the final sum is bounded by 2**ACC_W-1
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    fin_en |-> !fin_carry);
endmodule

// File: rtl/mwmac_ctrl.sv
module mwmac_ctrl
  import mwmac_pkg::*;
#(
  parameter int N_LIMBS = 3,
  parameter int IDX_W   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_op,
  input  logic             res_ready,
  output logic             req_ready,
  output logic             res_valid,
  output logic             acc_clr,
  output logic             mul_en,
  output logic [IDX_W-1:0] mul_idx,
  output logic             fin_en,
  output op_e              op_q
);
  localparam int LAT_W = $clog2(N_LIMBS + 2) + 1;
  localparam logic [IDX_W-1:0] LAST_ALL = IDX_W'(N_LIMBS - 1);

  state_e           st;
  logic [LAT_W-1:0] lat_cnt;
  logic [IDX_W-1:0] last_idx;

  assign req_ready = (st == S_IDLE);
  assign res_valid = (st == S_RESP);
  assign acc_clr   = req_ready && req_valid;
  assign mul_en    = (st == S_MUL);
  assign fin_en    = (st == S_FIN);
  assign last_idx  = (op_q == OP_ALL) ? LAST_ALL : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      mul_idx <= '0;
      op_q    <= OP_ONE;
    end else begin
      unique case (st)
        S_IDLE: if (req_valid) begin
          st      <= S_MUL;
          mul_idx <= '0;
          op_q    <= op_e'(req_op);
        end
        S_MUL: begin
          if (mul_idx == last_idx) st <= S_FIN;
          else mul_idx <= mul_idx + 1'b1;
        end
        S_FIN:  st <= S_RESP;
        S_RESP: if (res_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || acc_clr) lat_cnt <= '0;
    else if (mul_en || fin_en) lat_cnt <= lat_cnt + 1'b1;
  end

  p_ready_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(req_ready && res_valid));
  p_res_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |=> res_valid);
  p_latency_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(res_valid) |-> lat_cnt == ((op_q == OP_ALL) ? LAT_W'(N_LIMBS + 1) : LAT_W'(2)));
endmodule

// File: rtl/mwmac_unit.sv
module mwmac_unit
  import mwmac_pkg::*;
#(
  parameter int LIMB_W  = 64,
  parameter int N_LIMBS = 3,
  localparam int IDX_W  = (N_LIMBS > 1) ? $clog2(N_LIMBS) : 1,
  localparam int ACC_W  = LIMB_W * (N_LIMBS + 1),
  localparam int ST_W   = LIMB_W * N_LIMBS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_op,
  input  logic [LIMB_W-1:0] req_a,
  input  logic [LIMB_W-1:0] req_b,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [LIMB_W-1:0] res_data,
  input  logic              mpl_wr_en,
  input  logic [IDX_W-1:0]  mpl_wr_idx,
  input  logic [LIMB_W-1:0] mpl_wr_data,
  input  logic              p_wr_en,
  input  logic [IDX_W-1:0]  p_wr_idx,
  input  logic [LIMB_W-1:0] p_wr_data,
  output logic [ST_W-1:0]   p_q
);
  logic [LIMB_W-1:0]   mpl [N_LIMBS];
  logic [LIMB_W-1:0]   pw  [N_LIMBS];
  logic [LIMB_W-1:0]   a_q, b_q, mpl_sel;
  logic [2*LIMB_W-1:0] prod;
  logic [ACC_W-1:0]    addend, fin_sum;
  logic [ST_W-1:0]     mpl_flat;
  logic                acc_clr, mul_en, fin_en;
  logic [IDX_W-1:0]    mul_idx;
  op_e                 op_q;

  mwmac_ctrl #(.N_LIMBS(N_LIMBS), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .res_ready(res_ready), .req_ready(req_ready), .res_valid(res_valid),
    .acc_clr(acc_clr), .mul_en(mul_en), .mul_idx(mul_idx),
    .fin_en(fin_en), .op_q(op_q));

  // operand capture on acceptance
  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
    end else if (acc_clr) begin
      a_q <= req_a;
      b_q <= req_b;
    end
  end

  always_comb begin
    mpl_sel = '0;
    for (int i = 0; i < N_LIMBS; i++)
      if (mul_idx == IDX_W'(i)) mpl_sel = mpl[i];
  end

  mwmac_limb_mul #(.LIMB_W(LIMB_W)) u_mul (.x(mpl_sel), .y(a_q), .prod(prod));

  // addend folded in during the final cycle
  always_comb begin
    if (op_q == OP_ALL) addend = ACC_W'(p_q) + ACC_W'(b_q);
    else                addend = ACC_W'(pw[0]) + ACC_W'(b_q);
  end

  mwmac_accum #(.LIMB_W(LIMB_W), .N_LIMBS(N_LIMBS), .IDX_W(IDX_W)) u_acc (
    .clk(clk), .rst(rst), .clr(acc_clr), .mul_en(mul_en), .mul_idx(mul_idx),
    .prod(prod), .fin_en(fin_en), .addend(addend), .fin_sum(fin_sum));

  always_ff @(posedge clk) begin
    if (rst) res_data <= '0;
    else if (fin_en) res_data <= fin_sum[LIMB_W-1:0];
  end

  generate
    for (genvar i = 0; i < N_LIMBS; i++) begin : g_word
      always_ff @(posedge clk) begin
        if (rst) mpl[i] <= '0;
        else if (mpl_wr_en && req_ready && mpl_wr_idx == IDX_W'(i)) mpl[i] <= mpl_wr_data;
      end

      always_ff @(posedge clk) begin
        if (rst) pw[i] <= '0;
        else if (fin_en && (op_q == OP_ALL || i == 0))
          pw[i] <= fin_sum[(i+1)*LIMB_W +: LIMB_W];
        else if (p_wr_en && p_wr_idx == IDX_W'(i)) pw[i] <= p_wr_data;
      end

      assign p_q[i*LIMB_W +: LIMB_W]      = pw[i];
      assign mpl_flat[i*LIMB_W +: LIMB_W] = mpl[i];
    end
  endgenerate

  p_res_stable_r7: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |=> $stable(res_data));
  p_mpl_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    !req_ready |=> $stable(mpl_flat));
  p_wb_low_r8: assert property (@(posedge clk) disable iff (rst)
    fin_en |=> p_q[LIMB_W-1:0] == $past(fin_sum[2*LIMB_W-1:LIMB_W]));
endmodule

// File: tb/mwmac_unit_test.sv
module mwmac_unit_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_op = 1'b0, res_ready = 1'b0;
  logic [63:0] req_a = '0, req_b = '0;
  logic mpl_wr_en = 1'b0, p_wr_en = 1'b0;
  logic [1:0] mpl_wr_idx = '0, p_wr_idx = '0;
  logic [63:0] mpl_wr_data = '0, p_wr_data = '0;
  logic req_ready, res_valid;
  logic [63:0] res_data;
  logic [191:0] p_q;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [63:0] m [3];
  logic [63:0] pm [3];
  localparam logic [63:0] ONES = '1;

  always #2 clk = ~clk;

  mwmac_unit uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_a(req_a), .req_b(req_b), .res_valid(res_valid),
    .res_ready(res_ready), .res_data(res_data), .mpl_wr_en(mpl_wr_en),
    .mpl_wr_idx(mpl_wr_idx), .mpl_wr_data(mpl_wr_data), .p_wr_en(p_wr_en),
    .p_wr_idx(p_wr_idx), .p_wr_data(p_wr_data), .p_q(p_q));

  task automatic check(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load_mpl(input int idx, input logic [63:0] d);
    mpl_wr_en = 1'b1; mpl_wr_idx = 2'(idx); mpl_wr_data = d;
    step();
    mpl_wr_en = 1'b0;
    if (idx < 3) m[idx] = d;
  endtask

  task automatic load_p(input int idx, input logic [63:0] d);
    p_wr_en = 1'b1; p_wr_idx = 2'(idx); p_wr_data = d;
    step();
    p_wr_en = 1'b0;
    if (idx < 3) pm[idx] = d;
  endtask

  function automatic logic [255:0] model(input bit op, input logic [63:0] a,
                                         input logic [63:0] b);
    logic [255:0] s;
    if (op) s = {64'b0, m[2], m[1], m[0]} * {192'b0, a} + {192'b0, b}
              + {64'b0, pm[2], pm[1], pm[0]};
    else    s = {192'b0, m[0]} * {192'b0, a} + {192'b0, b} + {192'b0, pm[0]};
    return s;
  endfunction

  // issue one request, check latency, hold, result and carry update
  task automatic run_op(input bit op, input logic [63:0] a, input logic [63:0] b,
                        input int hold, input string tag);
    logic [255:0] s;
    int lat;
    logic [63:0] first;
    s = model(op, a, b);
    req_valid = 1'b1; req_op = op; req_a = a; req_b = b;
    step();
    req_valid = 1'b0;
    lat = 0;
    while (!res_valid && lat < 20) begin step(); lat++; end
    check(lat == (op ? 4 : 2), {tag, " R6 latency"}, lat, op ? 4 : 2);
    check(res_data == s[63:0], {tag, " R3/R4 result"}, res_data, s[63:0]);
    first = res_data;
    for (int k = 0; k < hold; k++) begin
      step();
      check(res_valid && !req_ready && res_data == first, {tag, " R7 hold"},
            {res_valid, req_ready, res_data}, {2'b10, first});
    end
    res_ready = 1'b1;
    step();
    res_ready = 1'b0;
    check(req_ready && !res_valid, {tag, " R7 consume"}, {req_ready, res_valid}, 2'b10);
    pm[0] = s[127:64];
    if (op) begin pm[1] = s[191:128]; pm[2] = s[255:192]; end
    check(p_q == {pm[2], pm[1], pm[0]}, {tag, " R3/R4 carry words"}, p_q,
          {pm[2], pm[1], pm[0]});
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) step();
    rst = 1'b0;
    m[0] = '0; m[1] = '0; m[2] = '0; pm[0] = '0; pm[1] = '0; pm[2] = '0;
    check(p_q == '0, "R1 carry zero", p_q, 0);
    check(req_ready && !res_valid, "R1 handshake idle", {req_ready, res_valid}, 2'b10);
    run_op(1'b1, ONES, 64'd0, 0, "R1 multiplier zero");
  endtask

  task automatic t_loads();
    load_p(0, 64'h1111); load_p(1, 64'h2222); load_p(2, 64'h3333);
    check(p_q == {64'h3333, 64'h2222, 64'h1111}, "R2 carry load", p_q,
          {64'h3333, 64'h2222, 64'h1111});
    load_p(3, 64'hdead);
    check(p_q == {64'h3333, 64'h2222, 64'h1111}, "R2 index 3 ignored", p_q,
          {64'h3333, 64'h2222, 64'h1111});
    load_mpl(3, 64'hbeef);
    load_mpl(0, 64'h5); load_mpl(1, 64'h7); load_mpl(2, 64'h9);
    run_op(1'b1, 64'h3, 64'h10, 0, "R2 mpl load");
  endtask

  task automatic t_single_rand();
    for (int i = 0; i < 4; i++) begin
      load_mpl(0, rnd64()); load_p(1, rnd64()); load_p(2, rnd64());
      run_op(1'b0, rnd64(), rnd64(), i, "R3 random");
    end
  endtask

  task automatic t_full_rand();
    for (int i = 0; i < 4; i++) begin
      load_mpl(0, rnd64()); load_mpl(1, rnd64()); load_mpl(2, rnd64());
      run_op(1'b1, rnd64(), rnd64(), i, "R4 random");
      run_op(1'b1, rnd64(), rnd64(), 0, "R4 chained");
    end
  endtask

  task automatic t_all_ones();
    for (int i = 0; i < 3; i++) begin load_mpl(i, ONES); load_p(i, ONES); end
    run_op(1'b1, ONES, ONES, 0, "R5 full ripple");
    check(p_q == {ONES, ONES, ONES}, "R5 full all ones", p_q, {ONES, ONES, ONES});
    load_p(0, ONES);
    run_op(1'b0, ONES, ONES, 0, "R5 one-limb ripple");
    check(pm[0] == ONES, "R5 one-limb high", pm[0], ONES);
  endtask

  task automatic t_collision();
    logic [255:0] s;
    load_mpl(0, rnd64()); load_p(0, rnd64()); load_p(1, 64'h44);
    s = model(1'b0, 64'h1234_5678_9abc_def0, 64'h77);
    req_valid = 1'b1; req_op = 1'b0; req_a = 64'h1234_5678_9abc_def0; req_b = 64'h77;
    step();
    req_valid = 1'b0;
    step();
    p_wr_en = 1'b1; p_wr_idx = 2'd0; p_wr_data = 64'hcafe;
    step();
    p_wr_en = 1'b0;
    check(p_q[63:0] == s[127:64], "R8 write-back wins", p_q[63:0], s[127:64]);
    p_wr_en = 1'b0;
    res_ready = 1'b1; step(); res_ready = 1'b0;
    pm[0] = s[127:64];
    // a different word loaded in the write-back cycle of a one-limb op
    s = model(1'b0, 64'h5, 64'h0);
    req_valid = 1'b1; req_op = 1'b0; req_a = 64'h5; req_b = 64'h0;
    step();
    req_valid = 1'b0;
    step();
    p_wr_en = 1'b1; p_wr_idx = 2'd1; p_wr_data = 64'habcd;
    step();
    p_wr_en = 1'b0;
    pm[0] = s[127:64]; pm[1] = 64'habcd;
    check(p_q == {pm[2], pm[1], pm[0]}, "R8 other word loads", p_q, {pm[2], pm[1], pm[0]});
    res_ready = 1'b1; step(); res_ready = 1'b0;
  endtask

  task automatic t_mpl_busy();
    logic [255:0] s;
    load_mpl(0, 64'h3); load_mpl(1, 64'h0); load_mpl(2, 64'h0);
    load_p(0, 0); load_p(1, 0); load_p(2, 0);
    s = model(1'b1, 64'h2, 64'h0);
    req_valid = 1'b1; req_op = 1'b1; req_a = 64'h2; req_b = 64'h0;
    step();
    req_valid = 1'b0;
    mpl_wr_en = 1'b1; mpl_wr_idx = 2'd1; mpl_wr_data = 64'h9;
    step();
    mpl_wr_idx = 2'd0; mpl_wr_data = 64'h8;
    repeat (4) step();
    mpl_wr_en = 1'b0;
    check(res_valid && res_data == s[63:0], "R9 busy load ignored", res_data, s[63:0]);
    check(p_q == '0, "R9 upper words unchanged", p_q, 0);
    res_ready = 1'b1; step(); res_ready = 1'b0;
    pm[0] = s[127:64]; pm[1] = s[191:128]; pm[2] = s[255:192];
    run_op(1'b1, 64'h1, 64'h0, 0, "R9 multiplier kept");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_loads();
    t_single_rand();
    t_full_rand();
    t_all_ones();
    t_collision();
    t_mpl_busy();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule